// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block controls a bank of 32 general-purpose pins through a small register window. Each pin has a direction bit, a driven value and a two-bit function selector. Software never writes the direction or the driven value directly. It writes a mask of ones to a "set" address or to a "clear" address, so that two agents can each change their own pins without a read-modify-write race.

Every pin input passes through a two-flop synchronizer before the block uses it. A third register holds the synchronized value from one cycle earlier, and the block compares the two to find edges. Rising and falling edges each have their own per-pin enable. An enabled edge sets a sticky pending bit. Software clears pending bits by writing ones to an acknowledge address. A single interrupt line to the host is high while any pending bit is set.

Register reads are combinational: `rdata` follows `addr` in the same cycle. A write is applied at the clock edge where `wr_en` is high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` = 0), `pin_out` = 0, every function select is 0, both edge enables are 0, no bit is pending and `irq` is low.
- R2: Writing ones to 0x04 sets those bits of the driven value and writing ones to 0x08 clears them. Zero bits in either write leave their bits unchanged. `pin_out` shows the driven value.
- R3: Writing ones to 0x14 makes those pins outputs and writing ones to 0x18 makes them inputs. Offset 0x10 reads the direction, with 1 meaning output, and `pin_oe` shows the same bits.
- R4: Offset 0x00 reads, for each pin, the driven value if the pin is an output and the synchronized input if it is an input. An input change made before clock edge k becomes visible after edge k+1.
- R5: Offsets 0x20 and 0x24 are read/write registers holding select bits A and B. `pin_func[2i+1:2i]` = {B[i], A[i]}: 00 is plain GPIO, 01 is function A, 10 is function B and 11 is function C.
- R6: With bit i of 0x40 set, a 0-to-1 change of input i made before edge k sets pending bit i at edge k+2.
- R7: With bit i of 0x44 set, a 1-to-0 change of input i sets pending bit i with the same latency as R6.
- R8: A pending bit is set only by an enabled edge. A steady level, or an edge whose enable is off, never sets a pending bit.
- R9: Offset 0x48 reads the pending bits. Writing ones to 0x4C clears those bits, and zero bits leave their pending bits unchanged.
- R10: `irq` is high exactly when at least one pending bit is set.
- R11: If an enabled edge and an acknowledge write hit the same bit at the same clock edge, the bit stays pending.
- R12: Writes to the read-only offsets (0x00, 0x10, 0x48) and to unmapped offsets change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Driven pin values |
| pin_oe | output | 32 | Per-pin output enable |
| pin_func | output | 64 | Per-pin function code, two bits per pin |
| irq | output | 1 | Aggregated interrupt, high while any bit is pending |

## Verification
Two functions can land on the same pending bit at the same clock edge: edge detection setting the bit and an acknowledge write clearing it. The bench first leaves the bit pending. It then lowers and raises the pin so that a fresh rising edge reaches the pending register two edges after the pin change, and it times the acknowledge write to be captured at exactly that edge. The bit is judged correct only if it still reads as pending afterwards. A later lone acknowledge must then clear it, which shows that the bit was held by the edge and not by a clear that failed to act.

// File: rtl/gpio_ctl_pkg.sv
// Package: shared address map, bus widths and function codes for the
// edge-interrupt GPIO controller. Assumes byte offsets on an 8-bit address.
package gpio_ctl_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DSET   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DCLR   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DIRSET = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIRCLR = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ALTA   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_ALTB   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FALL   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_PEND   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h4C;

    // Function code per pin: {select B, select A}
    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_A    = 2'b01,
        FN_B    = 2'b10,
        FN_C    = 2'b11
    } pin_fn_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Passes each pin through a two-flop synchronizer and keeps the previous
// synchronized value so that single-cycle rise and fall pulses can be made.
// Assumes pins are asynchronous to clk; the pulses are clk-synchronous.
module gpio_in_sync #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] level,
    output logic [N_PINS-1:0] rise,
    output logic [N_PINS-1:0] fall
);
    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;
    logic [N_PINS-1:0] prev_q;

    // Synchronizer chain plus one-cycle history register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge pulses from current versus previous synchronized level
    always_comb begin
        level = sync_q;
        rise  = sync_q & ~prev_q;
        fall  = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Holds the writable configuration: driven value, direction, two select
// planes and both edge enables. Data and direction change only through
// write-one set/clear offsets. Also decodes the acknowledge write into a
// per-pin clear mask for the pending logic. Assumes one access per cycle.
module gpio_cfg_regs
    import gpio_ctl_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_PINS-1:0] wdata,
    output logic [N_PINS-1:0] out_q,
    output logic [N_PINS-1:0] dir_q,
    output logic [N_PINS-1:0] alt_a_q,
    output logic [N_PINS-1:0] alt_b_q,
    output logic [N_PINS-1:0] rise_en_q,
    output logic [N_PINS-1:0] fall_en_q,
    output logic [N_PINS-1:0] ack_mask
);
    // Driven value: atomic set and clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_en && addr == OFS_DSET)
            out_q <= out_q | wdata;
        else if (wr_en && addr == OFS_DCLR)
            out_q <= out_q & ~wdata;
    end

    // Direction: atomic set (output) and clear (input)
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (wr_en && addr == OFS_DIRSET)
            dir_q <= dir_q | wdata;
        else if (wr_en && addr == OFS_DIRCLR)
            dir_q <= dir_q & ~wdata;
    end

    // Function select planes, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alt_a_q <= '0;
            alt_b_q <= '0;
        end else if (wr_en && addr == OFS_ALTA) begin
            alt_a_q <= wdata;
        end else if (wr_en && addr == OFS_ALTB) begin
            alt_b_q <= wdata;
        end
    end

    // Edge enables, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en && addr == OFS_RISE) begin
            rise_en_q <= wdata;
        end else if (wr_en && addr == OFS_FALL) begin
            fall_en_q <= wdata;
        end
    end

    // Acknowledge write decoded to a one-cycle clear mask
    always_comb begin
        ack_mask = (wr_en && addr == OFS_ACK) ? wdata : '0;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_q == '0 && dir_q == '0 && alt_a_q == '0 &&
                    alt_b_q == '0 && rise_en_q == '0 && fall_en_q == '0));

    // R2
    data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DSET) |=> ((out_q & $past(wdata)) == $past(wdata)));

    // R3
    dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DIRCLR) |=> ((dir_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_pend.sv
// Module: gpio_pend
// Sticky per-pin pending register fed by enabled edge pulses and cleared
// by a write-one mask. When an edge and a clear meet on one bit in one
// cycle, the edge wins. Drives the aggregated interrupt.
module gpio_pend #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] rise,
    input  logic [N_PINS-1:0] fall,
    input  logic [N_PINS-1:0] rise_en,
    input  logic [N_PINS-1:0] fall_en,
    input  logic [N_PINS-1:0] ack_mask,
    output logic [N_PINS-1:0] pending,
    output logic              irq
);
    logic [N_PINS-1:0] hit;

    // Qualify edge pulses with their enables
    always_comb begin
        hit = (rise & rise_en) | (fall & fall_en);
    end

    // Pending bits: clear first, then set so a new edge wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= '0;
        else
            pending <= (pending & ~ack_mask) | hit;
    end

    // Aggregated interrupt from any pending bit
    always_comb begin
        irq = |pending;
    end

    // R8
    set_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(hit)) == '0));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mask != '0) |=> ((pending & $past(ack_mask & ~hit)) == '0));

    // R11
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pending & $past(hit)) == $past(hit)));

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) != '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: gpio_edge_ctrl (top)
// Register-mapped controller for a bank of pins with per-pin direction,
// driven value, function select and edge interrupts. Reads are
// combinational on addr; writes take effect at the clock edge with wr_en.
module gpio_edge_ctrl
    import gpio_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [DATA_W-1:0]   pin_in,
    output logic [DATA_W-1:0]   pin_out,
    output logic [DATA_W-1:0]   pin_oe,
    output logic [2*DATA_W-1:0] pin_func,
    output logic                irq
);
    localparam int N_PINS = DATA_W;

    logic [N_PINS-1:0] level, rise, fall;
    logic [N_PINS-1:0] out_q, dir_q, alt_a_q, alt_b_q;
    logic [N_PINS-1:0] rise_en_q, fall_en_q, ack_mask, pending;
    logic [N_PINS-1:0] data_view;

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    gpio_cfg_regs #(.N_PINS(N_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .alt_a_q   (alt_a_q),
        .alt_b_q   (alt_b_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .ack_mask  (ack_mask)
    );

    gpio_pend #(.N_PINS(N_PINS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .fall     (fall),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .ack_mask (ack_mask),
        .pending  (pending),
        .irq      (irq)
    );

    // Per-pin function code {B, A}
    for (genvar i = 0; i < N_PINS; i++) begin : g_fn
        assign pin_func[2*i +: 2] = {alt_b_q[i], alt_a_q[i]};
    end

    // Pin-facing outputs
    always_comb begin
        pin_out   = out_q;
        pin_oe    = dir_q;
        data_view = (dir_q & out_q) | (~dir_q & level);
    end

    // Combinational read mux; unmapped offsets read zero
    always_comb begin
        case (addr)
            OFS_DATA: rdata = data_view;
            OFS_DIR:  rdata = dir_q;
            OFS_ALTA: rdata = alt_a_q;
            OFS_ALTB: rdata = alt_b_q;
            OFS_RISE: rdata = rise_en_q;
            OFS_FALL: rdata = fall_en_q;
            OFS_PEND: rdata = pending;
            default:  rdata = '0;
        endcase
    end

    // R5
    fn_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ALTA && wdata[0] && alt_b_q[0]) |=>
            (pin_func[1:0] == 2'b11));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic [63:0] pin_func;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_func(pin_func), .irq(irq)
    );

    // Register vectors: write address/data, then read address and expected value
    localparam int NV = 12;
    localparam logic [7:0]  V_WA [NV] = '{8'h14, 8'h04, 8'h08, 8'h18, 8'h00, 8'h20,
                                          8'h24, 8'h7C, 8'h04, 8'h40, 8'h44, 8'h10};
    localparam logic [31:0] V_WD [NV] = '{32'h0000_00FF, 32'h0000_000F, 32'h0000_0003,
                                          32'h0000_000F, 32'hFFFF_FFFF, 32'h0000_0005,
                                          32'h0000_0006, 32'h1234_5678, 32'h0000_0000,
                                          32'h0000_0F00, 32'h0000_F000, 32'hFFFF_FFFF};
    localparam logic [7:0]  V_RA [NV] = '{8'h10, 8'h00, 8'h00, 8'h10, 8'h00, 8'h20,
                                          8'h24, 8'h7C, 8'h00, 8'h40, 8'h44, 8'h10};
    localparam logic [31:0] V_EX [NV] = '{32'h0000_00FF, 32'h0000_000F, 32'h0000_000C,
                                          32'h0000_00F0, 32'h0000_0000, 32'h0000_0005,
                                          32'h0000_0006, 32'h0000_0000, 32'h0000_0000,
                                          32'h0000_0F00, 32'h0000_F000, 32'h0000_00F0};
    // Entries: R3, R2, R2, R3, R12, R5, R5, R12, R2, R6, R7, R12
    localparam int V_RQ [NV] = '{3, 2, 2, 3, 12, 5, 5, 12, 2, 6, 7, 12};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_func", pin_func, 0);
        chk("R1 irq", irq, 0);
        rd_reg(8'h48, v); chk("R1 pending", v, 0);
        rd_reg(8'h40, v); chk("R1 rise enable", v, 0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            wr_reg(V_WA[k], V_WD[k]);
            rd_reg(V_RA[k], v);
            chk($sformatf("R%0d vector %0d", V_RQ[k], k), v, V_EX[k]);
        end

        // R2 / R3 pins, R5 function codes {B,A}: pin0=A, pin1=B, pin2=C, pin3=GPIO
        chk("R2 pin_out", pin_out, 32'h0000_000C);
        chk("R3 pin_oe", pin_oe, 32'h0000_00F0);
        chk("R5 pin_func", pin_func[7:0], 8'h39);

        // R4 synchronizer latency
        pin_in[20] = 1'b1;
        tick();
        rd_reg(8'h00, v); chk("R4 early", v, 0);
        tick();
        rd_reg(8'h00, v); chk("R4 visible", v, 32'h0010_0000);
        tick();
        rd_reg(8'h48, v); chk("R8 no enable", v, 0);

        // R6 rising edge latency
        pin_in[8] = 1'b1;
        tick(); tick();
        rd_reg(8'h48, v); chk("R6 before", v, 0);
        tick();
        rd_reg(8'h48, v); chk("R6 pending", v, 32'h0000_0100);
        chk("R10 irq high", irq, 1);
        repeat (5) tick();
        rd_reg(8'h48, v); chk("R9 sticky", v, 32'h0000_0100);

        // R9 acknowledge
        wr_reg(8'h4C, 32'h0);
        rd_reg(8'h48, v); chk("R9 zero ack", v, 32'h0000_0100);
        wr_reg(8'h4C, 32'h0000_0100);
        rd_reg(8'h48, v); chk("R9 cleared", v, 0);
        chk("R10 irq low", irq, 0);
        repeat (5) tick();
        rd_reg(8'h48, v); chk("R8 steady level", v, 0);

        // R7 falling edge; rising on 12 not enabled
        pin_in[12] = 1'b1;
        repeat (4) tick();
        rd_reg(8'h48, v); chk("R8 rise disabled", v, 0);
        pin_in[12] = 1'b0;
        tick(); tick();
        rd_reg(8'h48, v); chk("R7 before", v, 0);
        tick();
        rd_reg(8'h48, v); chk("R7 pending", v, 32'h0000_1000);
        pin_in[8] = 1'b0;
        repeat (4) tick();
        rd_reg(8'h48, v); chk("R8 fall disabled", v, 32'h0000_1000);
        wr_reg(8'h4C, 32'h0000_1000);
        rd_reg(8'h48, v); chk("R9 clear fall", v, 0);

        // R12 write to read-only pending offset
        wr_reg(8'h48, 32'hFFFF_FFFF);
        rd_reg(8'h48, v); chk("R12 pending ro", v, 0);

        // R11 edge and acknowledge at the same clock edge
        pin_in[9] = 1'b1;
        repeat (3) tick();
        rd_reg(8'h48, v); chk("R11 setup", v, 32'h0000_0200);
        pin_in[9] = 1'b0;
        repeat (4) tick();
        pin_in[9] = 1'b1;
        tick(); tick();
        wr_reg(8'h4C, 32'h0000_0200);
        rd_reg(8'h48, v); chk("R11 edge wins", v, 32'h0000_0200);
        chk("R11 irq held", irq, 1);
        wr_reg(8'h4C, 32'h0000_0200);
        rd_reg(8'h48, v); chk("R11 later clear", v, 0);

        // R1 reset mid-run
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R1 rerun pin_oe", pin_oe, 0);
        chk("R1 rerun pin_func", pin_func, 0);
        rd_reg(8'h40, v); chk("R1 rerun rise enable", v, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule